// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a fixed set of peripheral sources (64 by default) and presents one request line and one winning vector number to the processor. Every source has a pending flag, an enable bit, a 5-bit priority made of a 3-bit major level and a 2-bit sub level, and a 32-bit per-vector offset word that software can store and read back. Some sources are persistent: their flag follows a held condition and cannot be cleared while the condition remains. The other sources are non-persistent: a rising edge on the request latches the flag, and software removes it.

A group of sources (8 by default, starting at source `EXT_BASE`) is driven by external pins. Each pin is passed through a two-stage synchronizer, and the selected edge of the synchronized pin latches the flag. A control bit per pin chooses that edge. Software reaches everything through a plain 32-bit register bus. Each control, flag, enable and priority register has three write views: one replaces the whole value, one clears the bits written as 1 and one sets them. This lets software mask, unmask and acknowledge a single source without a read-modify-write.

Top module: `vpic`

## Requirements
- R1: After reset every control, flag, enable, priority and offset register reads zero, `irq_o` is low and `cpu_vec_o` is zero.
- R2: The flag words sit at 0x040 and the enable words at 0x0C0, with consecutive words 0x10 apart. Source n occupies bit n%32 of word n/32. Addresses that match no register read as zero.
- R3: For the control (0x000), flag, enable and priority registers, a write at offset +0x0 replaces the value, a write at +0x4 clears the bits written as 1, a write at +0x8 sets the bits written as 1, and a write at +0xC has no effect. Reads at any of these offsets return the register. The control register keeps only its low `NUM_EXT` bits.
- R4: The priority of source n sits in the register at 0x140 + 0x10*(n/4), at bit offset (n%4)*8. It holds 5 bits: the major level in [4:2] and the sub level in [1:0]. Bits [7:5] of each lane are not stored and read as zero.
- R5: Of the sources with flag set, enable set and a nonzero major level, the winner is the one with the highest major level. Ties go to the higher sub level, then to the lower source number. A source with major level 0 never wins.
- R6: `irq_o` and `cpu_vec_o` are registered. They show the arbitration result of the register state one clock earlier. When there is no candidate, `irq_o` is 0 and the vector is 0.
- R7: A non-persistent source sets its flag in the cycle after its request rises from 0 to 1. A clear write removes the flag even while the request stays high. When a new rising edge falls in the same cycle as a clear write, the flag stays set.
- R8: A persistent source (bit set in `LEVEL_MASK`) holds its flag set while its request is 1 and ignores clear writes during that time. Once the request is 0, the flag stays set until it is cleared.
- R9: The flag of source `EXT_BASE+i` is set by an edge on `ext_i[i]` after a two-flop synchronizer. Control bit i = 1 selects the rising edge and 0 selects the falling edge. The `src_i` bit of such a source is ignored.
- R10: Source n has a 32-bit offset word at 0x540 + 4*n. It is written and read as a whole, and a write to one word leaves its neighbours unchanged.
- R11: The status register at 0x020 returns the current vector number in bits [7:0]. Writes to it have no effect.
- R12: A source whose enable bit is clear is not a candidate, but its flag still latches and can be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe for the current cycle |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| src_i | input | NUM_SRC | Peripheral request lines, one per source |
| ext_i | input | NUM_EXT | Asynchronous external interrupt pins |
| irq_o | output | 1 | Request to the processor |
| cpu_vec_o | output | 8 | Number of the winning source |

## Verification
The sharpest collision is a hardware request and a software clear landing on the same flag in the same cycle. The bench drops a non-persistent request for one cycle, then raises it on the same clock edge that carries a clear-alias write to that flag. It then reads the flag back, expecting 1, and checks that the source becomes the winner one cycle later. A second collision is a persistent source whose condition is held during a clear write: the flag must read 1 afterwards, and must read 0 only after the condition drops and the clear is repeated.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    // register groups, selected by address bits [11:4]
    localparam int GRP_CTRL = 'h00;
    localparam int GRP_STAT = 'h02;
    localparam int GRP_FLAG = 'h04;
    localparam int GRP_EN   = 'h0C;
    localparam int GRP_PRI  = 'h14;
    localparam int OFF_BASE = 'h540;

    // write view selected by address bits [3:2]
    typedef enum logic [1:0] {
        AL_WRITE = 2'd0,
        AL_CLR   = 2'd1,
        AL_SET   = 2'd2,
        AL_NONE  = 2'd3
    } alias_e;

    function automatic logic [31:0] alias_apply(logic [31:0] old, logic [31:0] wd, alias_e a);
        case (a)
            AL_WRITE: return wd;
            AL_CLR:   return old & ~wd;
            AL_SET:   return old | wd;
            default:  return old;
        endcase
    endfunction

    function automatic logic bit_apply(logic old, logic wd, alias_e a);
        case (a)
            AL_WRITE: return wd;
            AL_CLR:   return old & ~wd;
            AL_SET:   return old | wd;
            default:  return old;
        endcase
    endfunction

endpackage

// File: rtl/vpic_ext_edge.sv
module vpic_ext_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] pulse_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = pin_i;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // 1: rising, 0: falling
    assign pulse_o = (pol_i & r_q.s2 & ~r_q.s3) | (~pol_i & ~r_q.s2 & r_q.s3);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9
        pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[i] |=> (!pulse_o[i] || (pol_i[i] != $past(pol_i[i]))));
    end

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
    parameter int N  = 64,
    parameter int VW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        flag_i,
    input  logic [N-1:0]        en_i,
    input  logic [N-1:0][4:0]   pri_i,
    output logic                valid_o,
    output logic [VW-1:0]       vec_o
);

    logic [4:0] best;

    // strict compare keeps the lowest number on a full tie
    always_comb begin
        valid_o = 1'b0;
        vec_o   = '0;
        best    = '0;
        for (int i = 0; i < N; i++) begin
            if (flag_i[i] && en_i[i] && (pri_i[i][4:2] != 3'd0)) begin
                if (!valid_o || (pri_i[i] > best)) begin
                    valid_o = 1'b1;
                    best    = pri_i[i];
                    vec_o   = VW'(i);
                end
            end
        end
    end

    // R5
    winner_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (flag_i[vec_o] && en_i[vec_o] && (pri_i[vec_o][4:2] != 3'd0)));

endmodule

// File: rtl/vpic.sv
module vpic
    import vpic_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_EXT  = 8,
    parameter int EXT_BASE = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = {NUM_SRC{1'b1}} << (NUM_SRC - NUM_SRC/4)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_EXT-1:0] ext_i,
    output logic               irq_o,
    output logic [7:0]         cpu_vec_o
);

    localparam int VW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    function automatic logic [NUM_SRC-1:0] ext_mask_f();
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_EXT; i++) m[EXT_BASE+i] = 1'b1;
        return m;
    endfunction

    localparam logic [NUM_SRC-1:0] EXT_MASK = ext_mask_f();
    localparam logic [NUM_SRC-1:0] LVL_MASK = LEVEL_MASK & ~EXT_MASK;
    localparam logic [NUM_SRC-1:0] EDG_MASK = ~LEVEL_MASK & ~EXT_MASK;

    typedef struct packed {
        logic [NUM_EXT-1:0]          ctrl;
        logic [NUM_SRC-1:0]          flag;
        logic [NUM_SRC-1:0]          en;
        logic [NUM_SRC-1:0]          src_prev;
        logic [NUM_SRC-1:0][4:0]     pri;
        logic [NUM_SRC-1:0][31:0]    off;
        logic                        irq;
        logic [VW-1:0]               vec;
    } state_t;

    state_t s_q, s_d;
    logic   live_q;

    // address decode
    logic [7:0]    grp;
    alias_e        al;
    logic [11:0]   off_rel;
    logic          off_hit;
    logic [VW-1:0] off_idx;
    logic          unused_addr;

    assign grp         = bus_addr[11:4];
    assign al          = alias_e'(bus_addr[3:2]);
    assign off_rel     = bus_addr - 12'(OFF_BASE);
    assign off_hit     = (int'(bus_addr) >= OFF_BASE) && (int'(off_rel[11:2]) < NUM_SRC);
    assign off_idx     = off_rel[VW+1:2];
    assign unused_addr = ^bus_addr[1:0];

    // request sources
    logic [NUM_EXT-1:0] ext_pulse;
    logic [NUM_SRC-1:0] ext_req;
    logic [NUM_SRC-1:0] req;

    vpic_ext_edge #(.N(NUM_EXT)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (ext_i),
        .pol_i   (s_q.ctrl),
        .pulse_o (ext_pulse)
    );

    always_comb begin
        ext_req = '0;
        for (int i = 0; i < NUM_EXT; i++) ext_req[EXT_BASE+i] = ext_pulse[i];
    end

    assign req = (ext_req & EXT_MASK)
               | (src_i & LVL_MASK)
               | (src_i & ~s_q.src_prev & EDG_MASK);

    // arbitration
    logic          win_valid;
    logic [VW-1:0] win_vec;

    vpic_arb #(.N(NUM_SRC), .VW(VW)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_i  (s_q.flag),
        .en_i    (s_q.en),
        .pri_i   (s_q.pri),
        .valid_o (win_valid),
        .vec_o   (win_vec)
    );

    // next state
    always_comb begin
        s_d          = s_q;
        s_d.src_prev = src_i;
        s_d.irq      = win_valid;
        s_d.vec      = win_valid ? win_vec : '0;

        if (bus_we && off_hit) begin
            s_d.off[off_idx] = bus_wdata;
        end else if (bus_we) begin
            if (int'(grp) == GRP_CTRL)
                s_d.ctrl = NUM_EXT'(alias_apply(32'(s_q.ctrl), bus_wdata, al));
            for (int n = 0; n < NUM_SRC; n++) begin
                if (int'(grp) == GRP_FLAG + n/32)
                    s_d.flag[n] = bit_apply(s_q.flag[n], bus_wdata[n%32], al);
                if (int'(grp) == GRP_EN + n/32)
                    s_d.en[n] = bit_apply(s_q.en[n], bus_wdata[n%32], al);
                if (int'(grp) == GRP_PRI + n/4)
                    s_d.pri[n] = 5'(alias_apply(32'(s_q.pri[n]),
                                                32'(bus_wdata[(n%4)*8 +: 5]), al));
            end
        end

        // hardware requests win over a clear in the same cycle
        s_d.flag = s_d.flag | req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            live_q <= 1'b0;
        end else begin
            s_q    <= s_d;
            live_q <= 1'b1;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (off_hit) begin
            bus_rdata = s_q.off[off_idx];
        end else begin
            if (int'(grp) == GRP_CTRL) bus_rdata = 32'(s_q.ctrl);
            if (int'(grp) == GRP_STAT) bus_rdata = 32'(s_q.vec);
            for (int n = 0; n < NUM_SRC; n++) begin
                if (int'(grp) == GRP_FLAG + n/32) bus_rdata[n%32] = s_q.flag[n];
                if (int'(grp) == GRP_EN + n/32)   bus_rdata[n%32] = s_q.en[n];
                if (int'(grp) == GRP_PRI + n/4)   bus_rdata[(n%4)*8 +: 5] = s_q.pri[n];
            end
        end
    end

    assign irq_o     = s_q.irq;
    assign cpu_vec_o = 8'(s_q.vec);

    // R8
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ((src_i & LVL_MASK) != '0))
        |=> ((s_q.flag & $past(src_i & LVL_MASK)) == $past(src_i & LVL_MASK)));

    // R12
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en == '0) |=> !irq_o);

    // R6
    idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (cpu_vec_o == 8'd0));

endmodule

// File: tb/vpic_bench.sv
module vpic_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_i = '0;
    logic [7:0]  ext_i = '0;
    logic        irq_o;
    logic [7:0]  cpu_vec_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    vpic u_vpic (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_i     (src_i),
        .ext_i     (ext_i),
        .irq_o     (irq_o),
        .cpu_vec_o (cpu_vec_o)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  r;
    } tv_t;

    localparam int NT = 41;
    localparam tv_t TBL [NT] = '{
        '{1'b1, 12'h040, 32'hF0F00000, 32'h0,        4'd2},  // R2 flag word 0
        '{1'b0, 12'h040, 32'h0,        32'hF0F00000, 4'd2},
        '{1'b1, 12'h044, 32'hF0000000, 32'h0,        4'd3},  // R3 clear view
        '{1'b0, 12'h040, 32'h0,        32'h00F00000, 4'd3},
        '{1'b1, 12'h048, 32'h0000000F, 32'h0,        4'd3},  // R3 set view
        '{1'b0, 12'h040, 32'h0,        32'h00F0000F, 4'd3},
        '{1'b1, 12'h04C, 32'hFFFFFFFF, 32'h0,        4'd3},  // R3 +0xC ignored
        '{1'b0, 12'h040, 32'h0,        32'h00F0000F, 4'd3},
        '{1'b1, 12'h050, 32'h12345678, 32'h0,        4'd2},  // R2 flag word 1
        '{1'b0, 12'h050, 32'h0,        32'h12345678, 4'd2},
        '{1'b0, 12'h060, 32'h0,        32'h00000000, 4'd2},
        '{1'b1, 12'h040, 32'h0,        32'h0,        4'd2},
        '{1'b1, 12'h050, 32'h0,        32'h0,        4'd2},
        '{1'b1, 12'h0C0, 32'hA5A5A5A5, 32'h0,        4'd2},  // R2 enable bank
        '{1'b1, 12'h0C4, 32'h000000FF, 32'h0,        4'd3},
        '{1'b0, 12'h0C0, 32'h0,        32'hA5A5A500, 4'd3},
        '{1'b1, 12'h0D8, 32'h00000001, 32'h0,        4'd3},
        '{1'b0, 12'h0D0, 32'h0,        32'h00000001, 4'd2},
        '{1'b1, 12'h140, 32'hFFFFFFFF, 32'h0,        4'd4},  // R4 lanes
        '{1'b0, 12'h140, 32'h0,        32'h1F1F1F1F, 4'd4},
        '{1'b1, 12'h144, 32'h00000300, 32'h0,        4'd4},
        '{1'b0, 12'h140, 32'h0,        32'h1F1F1C1F, 4'd4},
        '{1'b1, 12'h150, 32'hE0E0E0E0, 32'h0,        4'd4},
        '{1'b0, 12'h150, 32'h0,        32'h00000000, 4'd4},
        '{1'b1, 12'h020, 32'hFFFFFFFF, 32'h0,        4'd11}, // R11
        '{1'b0, 12'h020, 32'h0,        32'h00000000, 4'd11},
        '{1'b1, 12'h000, 32'h000001FF, 32'h0,        4'd3},  // R3 control
        '{1'b0, 12'h000, 32'h0,        32'h000000FF, 4'd3},
        '{1'b1, 12'h004, 32'h0000000F, 32'h0,        4'd3},
        '{1'b0, 12'h000, 32'h0,        32'h000000F0, 4'd3},
        '{1'b1, 12'h000, 32'h0,        32'h0,        4'd3},
        '{1'b1, 12'h540, 32'hDEADBEEF, 32'h0,        4'd10}, // R10 offsets
        '{1'b0, 12'h540, 32'h0,        32'hDEADBEEF, 4'd10},
        '{1'b1, 12'h63C, 32'h0BADF00D, 32'h0,        4'd10},
        '{1'b0, 12'h63C, 32'h0,        32'h0BADF00D, 4'd10},
        '{1'b1, 12'h544, 32'h11111111, 32'h0,        4'd10},
        '{1'b0, 12'h540, 32'h0,        32'hDEADBEEF, 4'd10},
        '{1'b0, 12'h544, 32'h0,        32'h11111111, 4'd10},
        '{1'b1, 12'h0C0, 32'h0,        32'h0,        4'd2},
        '{1'b1, 12'h0D0, 32'h0,        32'h0,        4'd2},
        '{1'b1, 12'h140, 32'h0,        32'h0,        4'd4}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 32'd0);
        chk("R1 vec", 32'(cpu_vec_o), 32'd0);
        rd(12'h000, d); chk("R1 ctrl", d, 32'h0);
        rd(12'h040, d); chk("R1 flag", d, 32'h0);
        rd(12'h0C0, d); chk("R1 enable", d, 32'h0);
        rd(12'h140, d); chk("R1 priority", d, 32'h0);
        rd(12'h540, d); chk("R1 offset", d, 32'h0);

        // register table
        for (int k = 0; k < NT; k++) begin
            if (TBL[k].we) begin
                wr(TBL[k].a, TBL[k].d);
            end else begin
                rd(TBL[k].a, d);
                chk($sformatf("R%0d table entry %0d", TBL[k].r, k), d, TBL[k].e);
            end
        end

        // R5 / R6 arbitration
        wr(12'h0C0, 32'hFFFFFFFF);
        wr(12'h140, 32'h0D0E0000);   // src2 major3 sub2, src3 major3 sub1
        wr(12'h150, 32'h00000E00);   // src5 major3 sub2
        wr(12'h190, 32'h00000014);   // src20 major5 sub0
        wr(12'h048, 32'h0000002C);   // flags 2,3,5
        chk("R6 lag one cycle", 32'(irq_o), 32'd0);
        @(negedge clk);
        chk("R6 irq raised", 32'(irq_o), 32'd1);
        chk("R5 tie lowest number", 32'(cpu_vec_o), 32'd2);
        wr(12'h020, 32'hFFFFFFFF);
        rd(12'h020, d); chk("R11 status vector", d, 32'd2);
        wr(12'h048, 32'h00100000);
        @(negedge clk);
        chk("R5 major wins", 32'(cpu_vec_o), 32'd20);
        wr(12'h044, 32'h00100000);
        @(negedge clk);
        chk("R5 back to 2", 32'(cpu_vec_o), 32'd2);
        wr(12'h044, 32'h00000004);
        @(negedge clk);
        chk("R5 sub level", 32'(cpu_vec_o), 32'd5);
        wr(12'h044, 32'h00000020);
        @(negedge clk);
        chk("R5 last one", 32'(cpu_vec_o), 32'd3);

        // R12 masking
        wr(12'h0C4, 32'h00000008);
        @(negedge clk);
        chk("R12 masked irq", 32'(irq_o), 32'd0);
        chk("R12 masked vec", 32'(cpu_vec_o), 32'd0);
        rd(12'h040, d); chk("R12 flag kept", 32'(d[3]), 32'd1);
        wr(12'h0C8, 32'h00000008);
        @(negedge clk);
        chk("R12 unmasked", 32'(cpu_vec_o), 32'd3);

        // R5 major zero never wins
        wr(12'h144, 32'h1F000000);
        @(negedge clk);
        chk("R5 major zero irq", 32'(irq_o), 32'd0);
        chk("R6 idle vector", 32'(cpu_vec_o), 32'd0);
        wr(12'h040, 32'h0);
        wr(12'h140, 32'h0);

        // R7 non-persistent source 4
        wr(12'h150, 32'h0000001C);
        src_i[4] = 1'b1;
        @(negedge clk);
        rd(12'h040, d); chk("R7 edge latched", 32'(d[4]), 32'd1);
        wr(12'h044, 32'h00000010);
        rd(12'h040, d); chk("R7 clear while high", 32'(d[4]), 32'd0);
        @(negedge clk);
        src_i[4] = 1'b0;
        @(negedge clk);
        src_i[4]  = 1'b1;            // new edge together with a clear
        bus_we    = 1'b1;
        bus_addr  = 12'h044;
        bus_wdata = 32'h00000010;
        @(negedge clk);
        bus_we = 1'b0;
        rd(12'h040, d); chk("R7 edge beats clear", 32'(d[4]), 32'd1);
        @(negedge clk);
        chk("R7 winner", 32'(cpu_vec_o), 32'd4);
        src_i[4] = 1'b0;
        wr(12'h044, 32'h00000010);
        rd(12'h040, d); chk("R7 cleared", 32'(d[4]), 32'd0);

        // R8 persistent source 50
        src_i[50] = 1'b1;
        @(negedge clk);
        rd(12'h050, d); chk("R8 level latched", 32'(d[18]), 32'd1);
        wr(12'h054, 32'h00040000);
        rd(12'h050, d); chk("R8 clear ignored", 32'(d[18]), 32'd1);
        src_i[50] = 1'b0;
        @(negedge clk);
        rd(12'h050, d); chk("R8 stays after drop", 32'(d[18]), 32'd1);
        wr(12'h054, 32'h00040000);
        rd(12'h050, d); chk("R8 cleared", 32'(d[18]), 32'd0);

        // R9 external pin 2 -> source 10
        ext_i[2] = 1'b1;
        repeat (4) @(negedge clk);
        rd(12'h040, d); chk("R9 rising ignored", 32'(d[10]), 32'd0);
        ext_i[2] = 1'b0;
        repeat (4) @(negedge clk);
        rd(12'h040, d); chk("R9 falling latched", 32'(d[10]), 32'd1);
        wr(12'h044, 32'h00000400);
        wr(12'h008, 32'h00000004);
        ext_i[2] = 1'b1;
        repeat (4) @(negedge clk);
        rd(12'h040, d); chk("R9 rising latched", 32'(d[10]), 32'd1);
        wr(12'h044, 32'h00000400);
        src_i[10] = 1'b1;
        @(negedge clk);
        src_i[10] = 1'b0;
        @(negedge clk);
        rd(12'h040, d); chk("R9 src line ignored", 32'(d[10]), 32'd0);

        finish_run();
    end

endmodule